// File: doc/BRIEF.md
# SPI Flash Command Engine with Register Window

This block is a host-side SPI master that issues one short flash command at a time. Software sets up the command through an 8-entry byte register window: an opcode, up to three address bytes and one data byte, each in its own register. It then writes a single control byte. That byte starts the transfer and also selects the SCK speed, how many bytes go out and how many response bytes are clocked back. While the transfer runs, the engine drives chip-select, SCK and MOSI in SPI mode 0 with the most significant bit first. It captures up to three response bytes into read-only registers and reports a busy flag that software polls.

The register port is plain and synchronous. A write takes effect at the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr`. The port has no back-pressure: writes are never stalled, and a control write that arrives while a transfer is running is simply dropped. The engine supports only total command lengths of 1, 2, 4 and 5 bytes, counting the opcode, and at most 3 read bytes. The most significant address byte sits at the highest address offset and is sent first. Both SCK rates are made by dividing the system clock.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, `spi_cs_n` is 1 and `spi_sck` is 0. Offset 0 reads 0x00, and the response registers at offsets 5, 6 and 7 read 0x00.
- R2: A write to offset 0 starts a transfer only when the engine is idle and data bits 7:4 are 4 (slow clock) or 5 (fast clock). Any other value in bits 7:4 starts nothing and changes nothing.
- R3: Control bits 1:0 give the write length: code 0 sends 1 byte, 1 sends 2, 2 sends 4, and 3 sends 5. The wire order is: opcode (offset 1) first; then offset 4, offset 3, offset 2 for codes 2 and 3; and the data byte (offset 7) last for codes 1 and 3. The bus runs in mode 0: SCK idles low, bytes go MSB first, and MOSI is stable while SCK is high.
- R4: Control bits 3:2 give the read count N (0 to 3). N extra bytes are clocked after the write bytes with MOSI low. The first received byte lands at offset 5, the second at offset 6 and the third at offset 7. Response registers at or beyond N keep their old values.
- R5: Offset 0 reads {busy, 7'b0}. Busy is 1 from the clock after the starting write until chip-select is released.
- R6: SCK stays high and low for FAST_HALF system clocks each with control bit 4 set, and for SLOW_HALF system clocks each with it clear.
- R7: `spi_cs_n` is low for the whole transfer. It rises 2×half-period system clocks after the last SCK falling edge.
- R8: A write to offset 0 while busy is ignored: no extra transfer follows.
- R9: The outgoing bytes are taken from the registers at the start. Writes to offsets 1–4 or 7 during a transfer do not change it, but they do update the registers, and offsets 1–4 read back the values written to them.
- R10: Writes to offsets 5 and 6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| spi_sck | output | 1 | SPI serial clock, idles low |
| spi_cs_n | output | 1 | SPI chip-select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The main function is tried with every write-length code, at both clock speeds, and with read counts of 0, 1, 2 and 3. Distinct byte values in every register show whether the bytes are reordered, dropped or duplicated on the wire. A device model returns a different response stream for each transfer, so bytes captured at the wrong position, or response registers overwritten beyond the read count, are caught. Control writes with a wrong tag, control writes while busy, and register writes during a transfer each tell a correct engine apart from one that restarts, corrupts or reloads.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int BYTE_W = 8;
  localparam int TX_MAX = 5;   // longest command, opcode included
  localparam int RX_MAX = 3;   // most response bytes

  localparam logic [3:0] TAG_SLOW = 4'h4;
  localparam logic [3:0] TAG_FAST = 4'h5;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_OP   = 3'd1;
  localparam logic [2:0] OFS_ADL  = 3'd2;  // least significant address byte
  localparam logic [2:0] OFS_ADM  = 3'd3;
  localparam logic [2:0] OFS_ADH  = 3'd4;  // most significant, sent first
  localparam logic [2:0] OFS_RX0  = 3'd5;
  localparam logic [2:0] OFS_RX1  = 3'd6;
  localparam logic [2:0] OFS_DAT  = 3'd7;  // write: data byte, read: rx byte 2

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} eng_state_t;

  function automatic logic [2:0] wr_bytes(input logic [1:0] code);
    case (code)
      2'd0:    wr_bytes = 3'd1;
      2'd1:    wr_bytes = 3'd2;
      2'd2:    wr_bytes = 3'd4;
      default: wr_bytes = 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/spi_cmd_tick.sv
module spi_cmd_tick #(
  parameter int FAST_HALF = 2,
  parameter int SLOW_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int MAX_HALF = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
  localparam int CW = $clog2(MAX_HALF + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit = fast ? CW'(FAST_HALF - 1) : CW'(SLOW_HALF - 1);
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run)      cnt_q <= '0;
    else if (tick)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [2:0]                 bus_addr,
  input  logic [BYTE_W-1:0]          bus_wdata,
  output logic [BYTE_W-1:0]          bus_rdata,
  input  logic                       eng_busy,
  input  logic [RX_MAX-1:0]          rx_we,
  input  logic [RX_MAX*BYTE_W-1:0]   rx_bus,
  output logic                       start,
  output logic                       start_fast,
  output logic [1:0]                 start_wcode,
  output logic [1:0]                 start_rcnt,
  output logic [TX_MAX*BYTE_W-1:0]   tx_vec
);
  logic [BYTE_W-1:0] op_q, adl_q, adm_q, adh_q, dat_q;
  logic [BYTE_W-1:0] rx_q [RX_MAX];

  // start decode: idle engine, legal tag in the upper nibble
  assign start = bus_wr && (bus_addr == OFS_CTRL) && !eng_busy &&
                 ((bus_wdata[7:4] == TAG_SLOW) || (bus_wdata[7:4] == TAG_FAST));
  assign start_fast  = bus_wdata[4];
  assign start_rcnt  = bus_wdata[3:2];
  assign start_wcode = bus_wdata[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      adl_q <= '0;
      adm_q <= '0;
      adh_q <= '0;
      dat_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_OP:  op_q  <= bus_wdata;
        OFS_ADL: adl_q <= bus_wdata;
        OFS_ADM: adm_q <= bus_wdata;
        OFS_ADH: adh_q <= bus_wdata;
        OFS_DAT: dat_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  generate
    for (genvar i = 0; i < RX_MAX; i++) begin : g_rx
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rx_q[i] <= '0;
        else if (rx_we[i]) rx_q[i] <= rx_bus[i*BYTE_W +: BYTE_W];
      end
    end
  endgenerate

  // outgoing bytes, left aligned, in wire order
  always_comb begin
    case (start_wcode)
      2'd0:    tx_vec = {op_q, {4*BYTE_W{1'b0}}};
      2'd1:    tx_vec = {op_q, dat_q, {3*BYTE_W{1'b0}}};
      2'd2:    tx_vec = {op_q, adh_q, adm_q, adl_q, {BYTE_W{1'b0}}};
      default: tx_vec = {op_q, adh_q, adm_q, adl_q, dat_q};
    endcase
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL: bus_rdata = {eng_busy, 7'b0};
      OFS_OP:   bus_rdata = op_q;
      OFS_ADL:  bus_rdata = adl_q;
      OFS_ADM:  bus_rdata = adm_q;
      OFS_ADH:  bus_rdata = adh_q;
      OFS_RX0:  bus_rdata = rx_q[0];
      OFS_RX1:  bus_rdata = rx_q[1];
      default:  bus_rdata = rx_q[2];
    endcase
  end
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       start_fast,
  input  logic [1:0]                 start_wcode,
  input  logic [1:0]                 start_rcnt,
  input  logic [TX_MAX*BYTE_W-1:0]   tx_vec,
  input  logic                       tick,
  input  logic                       spi_miso,
  output logic                       spi_sck,
  output logic                       spi_cs_n,
  output logic                       spi_mosi,
  output logic                       busy,
  output logic                       fast_q,
  output logic [RX_MAX-1:0]          rx_we,
  output logic [RX_MAX*BYTE_W-1:0]   rx_bus
);
  localparam int TX_BITS = TX_MAX * BYTE_W;
  localparam int RX_BITS = RX_MAX * BYTE_W;
  localparam int CNT_W   = $clog2((TX_MAX + RX_MAX) * BYTE_W);

  eng_state_t          state_q;
  logic [TX_BITS-1:0]  tx_sr;
  logic [RX_BITS-1:0]  rx_sr;
  logic [CNT_W-1:0]    left_q;
  logic [1:0]          rcnt_q;
  logic                tail_q;
  logic [3:0]          nbytes;
  logic [CNT_W:0]      nbits;

  assign nbytes = {1'b0, wr_bytes(start_wcode)} + {2'b0, start_rcnt};
  assign nbits  = (CNT_W+1)'({nbytes, 3'b000});
  assign busy   = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      spi_sck  <= 1'b0;
      spi_cs_n <= 1'b1;
      spi_mosi <= 1'b0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      left_q   <= '0;
      rcnt_q   <= '0;
      fast_q   <= 1'b0;
      tail_q   <= 1'b0;
      rx_we    <= '0;
    end else begin
      rx_we <= '0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q  <= ST_SHIFT;
            spi_cs_n <= 1'b0;
            spi_sck  <= 1'b0;
            spi_mosi <= tx_vec[TX_BITS-1];
            tx_sr    <= tx_vec << 1;
            left_q   <= CNT_W'(nbits - 1'b1);
            rcnt_q   <= start_rcnt;
            fast_q   <= start_fast;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!spi_sck) begin
              spi_sck <= 1'b1;
              rx_sr   <= {rx_sr[RX_BITS-2:0], spi_miso};
            end else begin
              spi_sck <= 1'b0;
              if (left_q == '0) begin
                state_q  <= ST_TAIL;
                tail_q   <= 1'b0;
                spi_mosi <= 1'b0;
                for (int i = 0; i < RX_MAX; i++)
                  rx_we[i] <= (i < int'(rcnt_q));
              end else begin
                spi_mosi <= tx_sr[TX_BITS-1];
                tx_sr    <= tx_sr << 1;
                left_q   <= left_q - 1'b1;
              end
            end
          end
        end
        default: begin
          if (tick) begin
            if (tail_q) begin
              state_q  <= ST_IDLE;
              spi_cs_n <= 1'b1;
            end else begin
              tail_q <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  // last rcnt bytes of the shift register, first received byte to slot 0
  always_comb begin
    rx_bus = '0;
    for (int i = 0; i < RX_MAX; i++) begin
      int sh;
      sh = int'(rcnt_q) - 1 - i;
      if (sh >= 0)
        rx_bus[i*BYTE_W +: BYTE_W] = rx_sr[sh*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int FAST_HALF = 2,
  parameter int SLOW_HALF = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic                      eng_busy;
  logic                      start, start_fast, fast_q, tick;
  logic [1:0]                start_wcode, start_rcnt;
  logic [TX_MAX*BYTE_W-1:0]  tx_vec;
  logic [RX_MAX-1:0]         rx_we;
  logic [RX_MAX*BYTE_W-1:0]  rx_bus;

  spi_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(reg_wr), .bus_addr(reg_addr), .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
    .eng_busy(eng_busy), .rx_we(rx_we), .rx_bus(rx_bus),
    .start(start), .start_fast(start_fast), .start_wcode(start_wcode),
    .start_rcnt(start_rcnt), .tx_vec(tx_vec)
  );

  spi_cmd_tick #(.FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .fast(fast_q), .tick(tick)
  );

  spi_cmd_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_fast(start_fast), .start_wcode(start_wcode),
    .start_rcnt(start_rcnt), .tx_vec(tx_vec), .tick(tick), .spi_miso(spi_miso),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .busy(eng_busy), .fast_q(fast_q), .rx_we(rx_we), .rx_bus(rx_bus)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic       spi_sck,
  input logic       spi_cs_n,
  input logic       spi_mosi,
  input logic       eng_busy
);
  assert_idle_sck_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  assert_mosi_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  assert_busy_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd0) |-> (reg_rdata[7] == !spi_cs_n));

  assert_start_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(reg_wr && (reg_addr == 3'd0) && !eng_busy));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && reg_wr && (reg_addr == 3'd0)) |=> !$fell(spi_cs_n));

  assert_release_low_sck_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> !$past(spi_sck));

  assert_sck_only_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_sck) |-> !spi_cs_n);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi), .eng_busy(eng_busy)
);

// File: tb/spi_cmd_engine_tb.sv
module spi_cmd_engine_tb;
  localparam int FH = 2;
  localparam int SH = 4;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso = 0;

  spi_cmd_engine #(.FAST_HALF(FH), .SLOW_HALF(SH)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #4 clk = ~clk;  // 125 MHz

  typedef struct { logic [63:0] bits; int n; string tag; } exp_t;
  exp_t sb_q[$];

  int tests = 0, fails = 0, xfers = 0;
  int hi_run = 0, hi_meas = 0, low_run = 0, tail_meas = 0;
  logic prev_cs = 1;
  logic [63:0] sl_stream = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // device model: drives MISO from the stream, shifting on SCK falls
  initial forever begin
    int idx;
    @(negedge spi_cs_n);
    idx = 0;
    spi_miso = sl_stream[63];
    forever begin
      @(negedge spi_sck or posedge spi_cs_n);
      if (spi_cs_n) break;
      idx++;
      if (idx < 64) spi_miso = sl_stream[63-idx];
    end
  end

  // monitor: collects MOSI bits and pops the scoreboard at release
  initial forever begin
    logic [63:0] got;
    int n;
    @(negedge spi_cs_n);
    got = 0; n = 0;
    forever begin
      @(posedge spi_sck or posedge spi_cs_n);
      if (spi_cs_n) break;
      got = {got[62:0], spi_mosi};
      n++;
    end
    xfers++;
    if (sb_q.size() == 0) begin
      chk(0, "R8 unexpected transfer", 64'(n), 0);
    end else begin
      exp_t e;
      e = sb_q.pop_front();
      chk(n == e.n, {e.tag, " bit count"}, 64'(n), 64'(e.n));
      chk(got == e.bits, {e.tag, " wire bytes"}, got, e.bits);
    end
  end

  // SCK high time and release delay, in system clocks
  always @(negedge clk) begin
    if (!spi_cs_n) begin
      if (spi_sck) begin hi_run++; low_run = 0; end
      else begin
        if (hi_run != 0) hi_meas = hi_run;
        hi_run = 0;
        low_run++;
      end
    end else if (!prev_cs) begin
      tail_meas = low_run;
      low_run = 0;
    end
    prev_cs = spi_cs_n;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic int nwr(input logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 4 : 5;
  endfunction

  // driver: load registers, push expected wire bytes, start
  task automatic start_xfer(input logic [7:0] op, adh, adm, adl, dat,
                            input logic [1:0] wc, rc, input bit fast,
                            input logic [63:0] stream, input string tag);
    logic [7:0] b [8];
    exp_t e;
    int nb;
    wr(3'd1, op); wr(3'd4, adh); wr(3'd3, adm); wr(3'd2, adl); wr(3'd7, dat);
    for (int i = 0; i < 8; i++) b[i] = 0;
    b[0] = op;
    if (wc == 1) b[1] = dat;
    if (wc >= 2) begin b[1] = adh; b[2] = adm; b[3] = adl; end
    if (wc == 3) b[4] = dat;
    nb = nwr(wc) + int'(rc);
    e.bits = 0;
    for (int i = 0; i < nb; i++) e.bits = {e.bits[55:0], b[i]};
    e.n = nb * 8;
    e.tag = tag;
    sb_q.push_back(e);
    sl_stream = stream;
    wr(3'd0, {fast ? 4'h5 : 4'h4, rc, wc});
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] s;
    int k;
    rd(3'd0, s);
    chk(s == 8'h80, {tag, " R5 busy after start"}, s, 8'h80);
    k = 0;
    while (s[7] && k < 5000) begin rd(3'd0, s); k++; end
    chk(s == 8'h00 && spi_cs_n, {tag, " R5 busy clears with release"}, s, 0);
  endtask

  task automatic chk_rx(input logic [2:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    rd(a, d);
    chk(d == exp, tag, d, exp);
  endtask

  function automatic logic [7:0] sbyte(input logic [63:0] s, input int i);
    return s[63-8*i -: 8];
  endfunction

  initial begin
    logic [7:0] d;
    logic [63:0] s1, s2, s3;
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1 && spi_sck == 0, "R1 pins idle", {spi_cs_n, spi_sck}, 2'b10);
    chk_rx(3'd0, 8'h00, "R1 status reads zero");
    chk_rx(3'd5, 8'h00, "R1 rx0 zero");
    chk_rx(3'd7, 8'h00, "R1 rx2 zero");

    // R3/R4: 1-byte command, 3 read bytes, slow clock
    s1 = 64'hFF_C2_20_17_AA_BB_CC_DD;
    start_xfer(8'h9F, 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 2'd3, 0, s1, "R3 len1 rd3");
    wait_idle("R3 len1");
    chk_rx(3'd5, sbyte(s1, 1), "R4 first rx at offset 5");
    chk_rx(3'd6, sbyte(s1, 2), "R4 second rx at offset 6");
    chk_rx(3'd7, sbyte(s1, 3), "R4 third rx at offset 7");
    chk(hi_meas == SH, "R6 slow SCK high time", hi_meas, SH);
    chk(tail_meas == 2*SH, "R7 slow release delay", tail_meas, 2*SH);

    // R3: 2-byte command, fast
    start_xfer(8'h01, 8'h11, 8'h22, 8'h33, 8'h5A, 2'd1, 2'd0, 1, 64'h0, "R3 len2");
    wait_idle("R3 len2");
    chk(hi_meas == FH, "R6 fast SCK high time", hi_meas, FH);
    chk(tail_meas == 2*FH, "R7 fast release delay", tail_meas, 2*FH);

    // R3: 4-byte command, address high byte first
    start_xfer(8'hD8, 8'h12, 8'h34, 8'h56, 8'h99, 2'd2, 2'd0, 0, 64'h0, "R3 len4");
    wait_idle("R3 len4");

    // R3: 5-byte command
    start_xfer(8'h02, 8'hA1, 8'hB2, 8'hC3, 8'hE4, 2'd3, 2'd0, 1, 64'h0, "R3 len5");
    wait_idle("R3 len5");

    // R4: 4-byte command + 1 read byte, offsets 6/7 keep old values
    s2 = 64'h00_00_00_00_7E_81_42_24;
    start_xfer(8'h03, 8'h00, 8'h10, 8'h20, 8'h00, 2'd2, 2'd1, 1, s2, "R4 len4 rd1");
    wait_idle("R4 len4 rd1");
    chk_rx(3'd5, sbyte(s2, 4), "R4 rd1 offset 5");
    chk_rx(3'd6, sbyte(s1, 2), "R4 offset 6 unchanged");
    chk_rx(3'd7, sbyte(s1, 3), "R4 offset 7 unchanged");

    // R4: 2-byte command + 2 read bytes
    s3 = 64'h00_00_3C_C3_5A_00_00_00;
    start_xfer(8'h35, 8'h00, 8'h00, 8'h00, 8'h08, 2'd1, 2'd2, 0, s3, "R4 len2 rd2");
    wait_idle("R4 len2 rd2");
    chk_rx(3'd5, sbyte(s3, 2), "R4 rd2 offset 5");
    chk_rx(3'd6, sbyte(s3, 3), "R4 rd2 offset 6");
    chk_rx(3'd7, sbyte(s1, 3), "R4 rd2 offset 7 unchanged");

    // R2: bad tag starts nothing
    seen = xfers;
    wr(3'd0, 8'h60);
    repeat (40) @(negedge clk);
    chk(xfers == seen && spi_cs_n, "R2 bad tag ignored", xfers, seen);
    chk_rx(3'd0, 8'h00, "R2 still idle");

    // R8 + R9: control write and register writes during a transfer
    seen = xfers;
    start_xfer(8'hC7, 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 2'd0, 0, 64'h0, "R9 snapshot op");
    wr(3'd0, 8'h5F);
    wr(3'd1, 8'h4B);
    wait_idle("R8 busy write");
    repeat (60) @(negedge clk);
    chk(xfers == seen + 1 && spi_cs_n, "R8 no extra transfer", xfers, seen + 1);
    chk_rx(3'd1, 8'h4B, "R9 opcode readback");
    chk_rx(3'd4, 8'h00, "R9 address readback");

    // R10: writes to offsets 5, 6 ignored
    wr(3'd5, 8'hEE);
    wr(3'd6, 8'hEE);
    chk_rx(3'd5, sbyte(s3, 2), "R10 offset 5 write ignored");
    chk_rx(3'd6, sbyte(s3, 3), "R10 offset 6 write ignored");

    chk(sb_q.size() == 0, "R3 scoreboard drained", sb_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule